// File: doc/BRIEF.md
# Buffered Configuration Port Bridge

This block sits between a processor's memory-mapped register bus and a word-wide device configuration port. Software loads 32-bit words into a deep outbound queue and then issues a start command. The block hands the queued words to the port one by one until the queue is empty. For readback, software writes a word count and issues a read command. The block then accepts that many words from the port into a shallower inbound queue, and software pops them through a data register.

A done flag in the status register tells software when it may start the next transfer. Four port status lines are mirrored in the same register. Two occupancy registers report how much room or data the queues hold. An interrupt output combines four queue-level events through per-source enables and one master enable. A control register can also flush both queues or put the whole block back to its reset state.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset: status reads 0x1F with the port lines low, the outbound vacancy reads the outbound depth (1024), the inbound occupancy reads 0, the interrupt status reads 0 and `irq` is low.
- R2: A write to byte offset 0x100 appends one word to the outbound queue, and the vacancy register at 0x114 drops by one. A write while the queue holds 1024 words is discarded.
- R3: Writing control (0x10C) with bit 0 set while idle starts an outbound transfer. Queued words appear on `cp_out_data` in write order, one per cycle where `cp_out_valid` and `cp_out_ready` are both high. Status bit 0 (done) is low until the queue has emptied.
- R4: Writing control with bit 1 set while idle starts a readback of N words. N is held in bits 11:0 of the size register at 0x108; upper bits are dropped. `cp_in_req` is high only while words remain. Each word taken while `cp_in_req` and `cp_in_valid` are high is queued in arrival order and popped by reading 0x104. The occupancy at 0x118 counts the queued words.
- R5: The inbound queue stops taking words at 256. `cp_in_req` then stays low and done stays low until software pops words, and the readback then resumes.
- R6: A read of 0x104 with the inbound queue empty leaves the occupancy at 0, and later readbacks return their words in order.
- R7: A start command written while done is low is ignored. It is not queued for later.
- R8: Status bits 4:1 always read 1, and bits 8:5 mirror `cp_stat[3:0]`.
- R9: Interrupt status (0x20) uses bit 0 for outbound at least half full, bit 1 for inbound at least half full, bit 2 for outbound empty and bit 3 for inbound full. A bit is set when its condition rises. Writing 1 to a bit inverts it.
- R10: `irq` is high exactly when bit 31 of the master enable (0x1C) is set and some status bit is set whose matching bit in the enable register (0x28) is also set.
- R11: Control bit 2 empties both queues at the write edge. It keeps them empty, discarding pushes, until it is written back to 0.
- R12: Control bit 3 returns the master enable, enable, interrupt status and size registers to 0, empties both queues and ends any transfer, all at the write edge. Register writes are ignored until the bit is written back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; data returns the next cycle |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| cp_out_valid | output | 1 | Outbound word available on the port |
| cp_out_ready | input | 1 | Port accepts the outbound word this cycle |
| cp_out_data | output | 32 | Outbound word |
| cp_in_req | output | 1 | Bridge can take a readback word this cycle |
| cp_in_valid | input | 1 | Port presents a readback word |
| cp_in_data | input | 32 | Readback word |
| cp_stat | input | 4 | Port status lines mirrored into status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a readback that has stalled on a full inbound queue while done is still low. From there, software pops must let capture resume without losing or reordering any word. The stimulus requests 300 words with an irregular `cp_in_valid`, waits until the occupancy reads 256, and confirms that it stays there. It then drains the queue in bursts sized from the occupancy, compares each word with the words the port model handed over, and later aborts a 4095-word readback stalled the same way with the reset bit.

// File: rtl/cfgb_pkg.sv
// Shared constants for the configuration port bridge: register byte
// offsets, control and interrupt bit positions, and the engine state type.
package cfgb_pkg;
    localparam int ADDR_W = 9;
    localparam int WORD_W = 32;
    localparam int STAT_W = 4;
    localparam int IRQ_N  = 4;

    localparam logic [ADDR_W-1:0] A_GIE  = 9'h01C;
    localparam logic [ADDR_W-1:0] A_ISR  = 9'h020;
    localparam logic [ADDR_W-1:0] A_IER  = 9'h028;
    localparam logic [ADDR_W-1:0] A_WDAT = 9'h100;
    localparam logic [ADDR_W-1:0] A_RDAT = 9'h104;
    localparam logic [ADDR_W-1:0] A_SIZE = 9'h108;
    localparam logic [ADDR_W-1:0] A_CTRL = 9'h10C;
    localparam logic [ADDR_W-1:0] A_STAT = 9'h110;
    localparam logic [ADDR_W-1:0] A_WVAC = 9'h114;
    localparam logic [ADDR_W-1:0] A_ROCC = 9'h118;

    localparam int CTL_WSTART = 0;
    localparam int CTL_RSTART = 1;
    localparam int CTL_CLR    = 2;
    localparam int CTL_SRST   = 3;
    localparam int GIE_BIT    = 31;

    localparam int EV_WHALF  = 0;
    localparam int EV_RHALF  = 1;
    localparam int EV_WEMPTY = 2;
    localparam int EV_RFULL  = 3;

    // Event conditions as they stand with both queues empty
    localparam logic [IRQ_N-1:0] COND_AT_RESET = 4'b0100;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_WRITE = 2'd1,
        ENG_READ  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/cfgb_fifo.sv
// Single-clock word queue with a combinational head.
// Assumes: a push on a full queue and a pop on an empty queue are dropped;
// clr empties the queue and overrides push and pop in the same cycle.
module cfgb_fifo #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             full, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr] <= push_data;
    end

    // Pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/cfgb_engine.sv
// Transfer sequencer: drains the outbound queue to the port, or takes a
// sized number of readback words into the inbound queue.
// Assumes: starts are accepted only when idle, with write taking priority;
// abort returns it to idle at the next edge.
module cfgb_engine #(
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [SIZE_W-1:0] size,
    input  logic              wf_empty,
    input  logic              rf_full,
    input  logic              cp_out_ready,
    input  logic              cp_in_valid,
    output logic              cp_out_valid,
    output logic              wf_pop,
    output logic              cp_in_req,
    output logic              rf_push,
    output logic              done
);
    import cfgb_pkg::*;

    eng_state_t        state;
    logic [SIZE_W-1:0] remain;

    assign done         = (state == ENG_IDLE);
    assign cp_out_valid = (state == ENG_WRITE) && !wf_empty;
    assign wf_pop       = cp_out_valid && cp_out_ready;
    assign cp_in_req    = (state == ENG_READ) && (remain != '0) && !rf_full;
    assign rf_push      = cp_in_req && cp_in_valid;

    // State and remaining-word counter
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state  <= ENG_IDLE;
            remain <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start_wr) begin
                        state <= ENG_WRITE;
                    end else if (start_rd) begin
                        state  <= ENG_READ;
                        remain <= size;
                    end
                end
                ENG_WRITE: begin
                    if (wf_empty) state <= ENG_IDLE;
                end
                ENG_READ: begin
                    if (remain == '0)  state  <= ENG_IDLE;
                    else if (rf_push)  remain <= remain - 1'b1;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgb_irq.sv
// Interrupt registers: edge-latched status with write-one-to-invert,
// per-source enables, master enable, and the combined request.
// Assumes: hold forces every register back to its reset value.
module cfgb_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] cond,
    input  logic         isr_wr,
    input  logic         ier_wr,
    input  logic         gie_wr,
    input  logic [N-1:0] wbits,
    input  logic         gie_wbit,
    output logic [N-1:0] isr,
    output logic [N-1:0] ier,
    output logic         gie,
    output logic         irq
);
    import cfgb_pkg::*;

    logic [N-1:0] prev;

    assign irq = gie && |(isr & ier);

    // Status, enable and previous-condition registers
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            isr  <= '0;
            ier  <= '0;
            gie  <= 1'b0;
            prev <= N'(COND_AT_RESET);
        end else begin
            prev <= cond;
            isr  <= (isr ^ (isr_wr ? wbits : '0)) | (cond & ~prev);
            if (ier_wr) ier <= wbits;
            if (gie_wr) gie <= gie_wbit;
        end
    end
endmodule

// File: rtl/cfgport_bridge.sv
// Register-mapped bridge between a processor bus and a configuration port.
// Decodes register accesses, owns the size and control levels, and ties the
// two queues, the transfer sequencer and the interrupt logic together.
// Assumes: one access per strobe; read data is registered one cycle after
// bus_rd_en; the reset and clear control bits act at the write edge.
module cfgport_bridge #(
    parameter int WF_DEPTH = 1024,
    parameter int RF_DEPTH = 256,
    parameter int SIZE_W   = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr_en,
    input  logic                          bus_rd_en,
    input  logic [cfgb_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [cfgb_pkg::WORD_W-1:0]   bus_wdata,
    output logic [cfgb_pkg::WORD_W-1:0]   bus_rdata,
    output logic                          cp_out_valid,
    input  logic                          cp_out_ready,
    output logic [cfgb_pkg::WORD_W-1:0]   cp_out_data,
    output logic                          cp_in_req,
    input  logic                          cp_in_valid,
    input  logic [cfgb_pkg::WORD_W-1:0]   cp_in_data,
    input  logic [cfgb_pkg::STAT_W-1:0]   cp_stat,
    output logic                          irq
);
    import cfgb_pkg::*;

    localparam int WF_CNT_W = $clog2(WF_DEPTH) + 1;
    localparam int RF_CNT_W = $clog2(RF_DEPTH) + 1;

    logic                wr_gie, wr_isr, wr_ier, wr_wdat, wr_size, wr_ctrl, rd_rdat;
    logic                srst_q, clr_q, srst_now, clr_now, hold, fifo_clr;
    logic                start_wr, start_rd, done;
    logic [SIZE_W-1:0]   size_q;
    logic [WF_CNT_W-1:0] wf_count;
    logic [RF_CNT_W-1:0] rf_count;
    logic                wf_empty, rf_empty, rf_full, wf_pop, rf_push;
    logic [WORD_W-1:0]   rf_head, rd_mux;
    logic [IRQ_N-1:0]    cond, isr_q, ier_q;
    logic                gie_q;

    // Access decode
    assign wr_gie  = bus_wr_en && (bus_addr == A_GIE);
    assign wr_isr  = bus_wr_en && (bus_addr == A_ISR);
    assign wr_ier  = bus_wr_en && (bus_addr == A_IER);
    assign wr_wdat = bus_wr_en && (bus_addr == A_WDAT);
    assign wr_size = bus_wr_en && (bus_addr == A_SIZE);
    assign wr_ctrl = bus_wr_en && (bus_addr == A_CTRL);
    assign rd_rdat = bus_rd_en && (bus_addr == A_RDAT);

    // Control decode: reset and clear act in the cycle they are written
    assign srst_now = wr_ctrl && bus_wdata[CTL_SRST];
    assign clr_now  = wr_ctrl && bus_wdata[CTL_CLR];
    assign hold     = srst_q || srst_now;
    assign fifo_clr = hold || clr_q || clr_now;
    assign start_wr = wr_ctrl && bus_wdata[CTL_WSTART];
    assign start_rd = wr_ctrl && bus_wdata[CTL_RSTART];
    assign rf_full  = (rf_count == RF_CNT_W'(RF_DEPTH));

    // Level bits of the control register; always writable so they can be released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
            clr_q  <= 1'b0;
        end else if (wr_ctrl) begin
            srst_q <= bus_wdata[CTL_SRST];
            clr_q  <= bus_wdata[CTL_CLR];
        end
    end

    // Readback word-count register
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  size_q <= '0;
        else if (wr_size)    size_q <= bus_wdata[SIZE_W-1:0];
    end

    cfgb_fifo #(.DEPTH(WF_DEPTH), .WIDTH(WORD_W)) u_wfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (wr_wdat),
        .push_data (bus_wdata),
        .pop       (wf_pop),
        .head      (cp_out_data),
        .count     (wf_count),
        .empty     (wf_empty)
    );

    cfgb_fifo #(.DEPTH(RF_DEPTH), .WIDTH(WORD_W)) u_rfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (rf_push),
        .push_data (cp_in_data),
        .pop       (rd_rdat),
        .head      (rf_head),
        .count     (rf_count),
        .empty     (rf_empty)
    );

    cfgb_engine #(.SIZE_W(SIZE_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (hold),
        .start_wr     (start_wr),
        .start_rd     (start_rd),
        .size         (size_q),
        .wf_empty     (wf_empty),
        .rf_full      (rf_full),
        .cp_out_ready (cp_out_ready),
        .cp_in_valid  (cp_in_valid),
        .cp_out_valid (cp_out_valid),
        .wf_pop       (wf_pop),
        .cp_in_req    (cp_in_req),
        .rf_push      (rf_push),
        .done         (done)
    );

    // Event conditions watched by the interrupt logic
    always_comb begin
        cond            = '0;
        cond[EV_WHALF]  = (wf_count >= WF_CNT_W'(WF_DEPTH / 2));
        cond[EV_RHALF]  = (rf_count >= RF_CNT_W'(RF_DEPTH / 2));
        cond[EV_WEMPTY] = wf_empty;
        cond[EV_RFULL]  = rf_full;
    end

    cfgb_irq #(.N(IRQ_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .cond     (cond),
        .isr_wr   (wr_isr),
        .ier_wr   (wr_ier),
        .gie_wr   (wr_gie),
        .wbits    (bus_wdata[IRQ_N-1:0]),
        .gie_wbit (bus_wdata[GIE_BIT]),
        .isr      (isr_q),
        .ier      (ier_q),
        .gie      (gie_q),
        .irq      (irq)
    );

    // Register read selection
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_GIE:  rd_mux[GIE_BIT] = gie_q;
            A_ISR:  rd_mux = WORD_W'(isr_q);
            A_IER:  rd_mux = WORD_W'(ier_q);
            A_RDAT: rd_mux = rf_empty ? '0 : rf_head;
            A_SIZE: rd_mux = WORD_W'(size_q);
            A_CTRL: begin
                rd_mux[CTL_SRST] = srst_q;
                rd_mux[CTL_CLR]  = clr_q;
            end
            A_STAT: rd_mux = WORD_W'({cp_stat, 4'hF, done});
            A_WVAC: rd_mux = WORD_W'(WF_CNT_W'(WF_DEPTH) - wf_count);
            A_ROCC: rd_mux = WORD_W'(rf_count);
            default: rd_mux = '0;
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/cfgb_checker.sv
// Property checker for the configuration port bridge, attached by bind.
// Assumes: it sees the queue counts and control strobes of the bound top.
module cfgb_checker #(
    parameter int WF_DEPTH = 1024,
    parameter int RF_DEPTH = 256,
    localparam int WF_CNT_W = $clog2(WF_DEPTH) + 1,
    localparam int RF_CNT_W = $clog2(RF_DEPTH) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                srst_now,
    input logic                clr_now,
    input logic                fifo_clr,
    input logic                done,
    input logic                gie,
    input logic                irq,
    input logic [WF_CNT_W-1:0] wf_count,
    input logic [RF_CNT_W-1:0] rf_count,
    input logic                cp_out_valid,
    input logic                cp_out_ready,
    input logic [31:0]         cp_out_data,
    input logic                cp_in_req
);
    // R2: the outbound count never exceeds its depth
    p_wvac_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wf_count <= WF_CNT_W'(WF_DEPTH));

    // R2: a full outbound queue stays full unless drained or flushed
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_count == WF_CNT_W'(WF_DEPTH)) && !(cp_out_valid && cp_out_ready) && !fifo_clr
        |=> wf_count == WF_CNT_W'(WF_DEPTH));

    // R3: outbound words are offered only during a transfer
    p_out_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cp_out_valid |-> !done);

    // R3: a stalled outbound word is held
    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cp_out_valid && !cp_out_ready && !fifo_clr
        |=> cp_out_valid && $stable(cp_out_data));

    // R4: readback requests only while a transfer runs
    p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_in_req |-> !done);

    // R5: the inbound queue never overflows
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_count <= RF_CNT_W'(RF_DEPTH));

    // R10: no request without the master enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    // R11: clearing empties both queues at the write edge
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (rf_count == '0) && (wf_count == '0));

    // R12: soft reset ends any transfer and empties the queues
    p_sreset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        srst_now |=> done && (rf_count == '0) && (wf_count == '0) && !irq);
endmodule

bind cfgport_bridge cfgb_checker #(
    .WF_DEPTH (WF_DEPTH),
    .RF_DEPTH (RF_DEPTH)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst_now     (srst_now),
    .clr_now      (clr_now),
    .fifo_clr     (fifo_clr),
    .done         (done),
    .gie          (gie_q),
    .irq          (irq),
    .wf_count     (wf_count),
    .rf_count     (rf_count),
    .cp_out_valid (cp_out_valid),
    .cp_out_ready (cp_out_ready),
    .cp_out_data  (cp_out_data),
    .cp_in_req    (cp_in_req)
);

// File: tb/test_cfgport_bridge.sv
// Self-checking bench: random port timing and data from a seeded $urandom,
// with directed corner cases; expected values come from bench functions.
module test_cfgport_bridge;
    localparam int WFD = 1024;
    localparam int RFD = 256;
    localparam logic [8:0] O_GIE = 9'h01C, O_ISR = 9'h020, O_IER = 9'h028,
                           O_WDAT = 9'h100, O_RDAT = 9'h104, O_SIZE = 9'h108,
                           O_CTRL = 9'h10C, O_STAT = 9'h110, O_WVAC = 9'h114,
                           O_ROCC = 9'h118;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en, bus_rd_en;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        cp_out_valid, cp_out_ready;
    logic [31:0] cp_out_data;
    logic        cp_in_req, cp_in_valid;
    logic [31:0] cp_in_data;
    logic [3:0]  cp_stat;
    logic        irq;

    int unsigned n_cmp = 0, n_bad = 0, in_idx = 0;
    logic [31:0] wr_exp[$], got_out[$], rd_exp[$];

    always #4 clk = ~clk;

    cfgport_bridge i_cfgport_bridge (
        .clk (clk), .rst_n (rst_n), .bus_wr_en (bus_wr_en), .bus_rd_en (bus_rd_en),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .cp_out_valid (cp_out_valid), .cp_out_ready (cp_out_ready),
        .cp_out_data (cp_out_data), .cp_in_req (cp_in_req),
        .cp_in_valid (cp_in_valid), .cp_in_data (cp_in_data),
        .cp_stat (cp_stat), .irq (irq)
    );

    function automatic logic [31:0] exp_status(logic dn, logic [3:0] st);
        return {23'd0, st, 4'hF, dn};
    endfunction

    function automatic logic exp_irq(logic [31:0] g, logic [3:0] en, logic [3:0] st);
        return g[31] && |(en & st);
    endfunction

    function automatic logic [31:0] gen_word(int unsigned i);
        return (i * 32'h9E3779B9) ^ 32'hC0FFEE00;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_done(int max_polls);
        logic [31:0] s;
        for (int k = 0; k < max_polls; k++) begin
            bus_read(O_STAT, s);
            if (s[0]) return;
        end
    endtask

    task automatic poll_occ(int target);
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            bus_read(O_ROCC, v);
            if (v >= target) return;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Port model: irregular ready and valid, records every transfer
    always begin
        @(negedge clk);
        cp_out_ready = ($urandom % 4) != 0;
        cp_in_valid  = ($urandom % 3) != 0;
        cp_in_data   = gen_word(in_idx);
        #1;
        if (cp_out_valid && cp_out_ready) got_out.push_back(cp_out_data);
        if (cp_in_req && cp_in_valid) begin
            rd_exp.push_back(cp_in_data);
            in_idx++;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, w;
        int unsigned popped;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0;
        bus_wdata = '0; cp_stat = 4'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(O_STAT, v); chk("R1 status", v, exp_status(1'b1, 4'h0));
        bus_read(O_WVAC, v); chk("R1 vacancy", v, WFD);
        bus_read(O_ROCC, v); chk("R1 occupancy", v, 0);
        bus_read(O_ISR, v);  chk("R1 isr", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R8: status mirrors port lines
        cp_stat = 4'hA; bus_read(O_STAT, v); chk("R8 status A", v, exp_status(1'b1, 4'hA));
        cp_stat = 4'h5; bus_read(O_STAT, v); chk("R8 status 5", v, exp_status(1'b1, 4'h5));
        cp_stat = 4'h0;

        // R2, R3, R7: short outbound transfer with a start issued while busy
        wr_exp.delete(); got_out.delete();
        for (int i = 0; i < 20; i++) begin
            w = $urandom; wr_exp.push_back(w); bus_write(O_WDAT, w);
        end
        bus_read(O_WVAC, v); chk("R2 vacancy after 20", v, WFD - 20);
        bus_write(O_SIZE, 5);
        bus_write(O_CTRL, 32'h1);
        bus_read(O_STAT, v); chk("R3 done low while sending", 32'(v[0]), 0);
        bus_write(O_CTRL, 32'h2);
        wait_done(500);
        chk("R3 word count", got_out.size(), 20);
        for (int i = 0; i < 20 && i < got_out.size(); i++) chk("R3 word order", got_out[i], wr_exp[i]);
        repeat (20) @(negedge clk);
        bus_read(O_ROCC, v); chk("R7 busy start ignored", v, 0);

        // R2: overfill the outbound queue, R9 half-full event
        wr_exp.delete(); got_out.delete();
        for (int i = 0; i < WFD + 6; i++) begin
            w = $urandom; if (i < WFD) wr_exp.push_back(w); bus_write(O_WDAT, w);
        end
        bus_read(O_WVAC, v); chk("R2 vacancy full", v, 0);
        bus_read(O_ISR, v);  chk("R9 half-full latched", 32'(v[0]), 1);
        bus_write(O_CTRL, 32'h1);
        wait_done(4000);
        chk("R2 drained count", got_out.size(), WFD);
        for (int i = 0; i < WFD && i < got_out.size(); i++) chk("R2 drained order", got_out[i], wr_exp[i]);
        bus_read(O_WVAC, v); chk("R2 vacancy restored", v, WFD);

        // R4: sized readback, upper size bits dropped
        rd_exp.delete();
        bus_write(O_SIZE, 32'h0000_1028);
        bus_read(O_SIZE, v); chk("R4 size width", v, 32'h28);
        bus_write(O_CTRL, 32'h2);
        wait_done(500);
        bus_read(O_ROCC, v); chk("R4 occupancy", v, 40);
        chk("R4 captured count", rd_exp.size(), 40);
        for (int i = 0; i < 40; i++) begin
            bus_read(O_RDAT, v); chk("R4 readback word", v, rd_exp[i]);
        end

        // R6: pop from empty, then a fresh readback stays ordered
        bus_read(O_RDAT, v);
        bus_read(O_ROCC, v); chk("R6 no underflow", v, 0);
        rd_exp.delete();
        bus_write(O_SIZE, 3); bus_write(O_CTRL, 32'h2);
        wait_done(200);
        bus_read(O_ROCC, v); chk("R6 occupancy", v, 3);
        for (int i = 0; i < 3; i++) begin
            bus_read(O_RDAT, v); chk("R6 word after empty pop", v, rd_exp[i]);
        end

        // R5: readback larger than the inbound queue
        rd_exp.delete();
        bus_write(O_SIZE, 300); bus_write(O_CTRL, 32'h2);
        poll_occ(RFD);
        bus_read(O_ROCC, v); chk("R5 stalls at depth", v, RFD);
        bus_read(O_STAT, v); chk("R5 done low while stalled", 32'(v[0]), 0);
        repeat (30) @(negedge clk);
        bus_read(O_ROCC, v); chk("R5 stays paused", v, RFD);
        popped = 0;
        for (int g = 0; g < 2000 && popped < 300; g++) begin
            bus_read(O_ROCC, w);
            for (int k = 0; k < w; k++) begin
                bus_read(O_RDAT, v);
                if (popped < rd_exp.size()) chk("R5 resumed word", v, rd_exp[popped]);
                popped++;
            end
        end
        wait_done(200);
        chk("R5 total words", popped, 300);
        bus_read(O_ISR, v); chk("R9 full event latched", 32'(v[3]), 1);

        // R9, R10: toggle and edge latching, interrupt gating
        bus_read(O_ISR, v); bus_write(O_ISR, v);
        bus_read(O_ISR, v); chk("R9 toggle clears", v, 0);
        bus_write(O_IER, 32'hF); bus_write(O_GIE, 32'h0);
        bus_write(O_WDAT, 32'h1234_5678); bus_write(O_CTRL, 32'h1);
        wait_done(100);
        bus_read(O_ISR, v); chk("R9 empty edge", v, 4);
        chk("R10 masked by master", 32'(irq), 32'(exp_irq(32'h0, 4'hF, 4'h4)));
        bus_write(O_GIE, 32'h8000_0000);
        chk("R10 master on", 32'(irq), 32'(exp_irq(32'h8000_0000, 4'hF, 4'h4)));
        bus_write(O_GIE, 32'h7FFF_FFFF);
        chk("R10 only bit 31", 32'(irq), 32'(exp_irq(32'h7FFF_FFFF, 4'hF, 4'h4)));
        bus_write(O_GIE, 32'h8000_0000);
        bus_write(O_IER, 32'hB);
        chk("R10 source masked", 32'(irq), 32'(exp_irq(32'h8000_0000, 4'hB, 4'h4)));
        bus_write(O_IER, 32'h4);
        chk("R10 source enabled", 32'(irq), 32'(exp_irq(32'h8000_0000, 4'h4, 4'h4)));
        bus_write(O_ISR, 32'h4);
        bus_read(O_ISR, v); chk("R9 toggle off", v, 0);
        chk("R10 cleared", 32'(irq), 0);
        bus_write(O_ISR, 32'h2);
        bus_read(O_ISR, v); chk("R9 toggle on", v, 2);
        bus_write(O_ISR, 32'h2);

        // R11: flush both queues, held while the bit stays set
        for (int i = 0; i < 5; i++) bus_write(O_WDAT, $urandom);
        bus_read(O_WVAC, v); chk("R11 vacancy before", v, WFD - 5);
        bus_write(O_SIZE, 3); bus_write(O_CTRL, 32'h2);
        wait_done(200);
        bus_read(O_ROCC, v); chk("R11 occupancy before", v, 3);
        bus_write(O_CTRL, 32'h4);
        bus_read(O_WVAC, v); chk("R11 outbound flushed", v, WFD);
        bus_read(O_ROCC, v); chk("R11 inbound flushed", v, 0);
        bus_write(O_WDAT, 32'hDEAD_BEEF);
        bus_read(O_WVAC, v); chk("R11 push held off", v, WFD);
        bus_write(O_CTRL, 32'h0);
        bus_write(O_WDAT, 32'hDEAD_BEEF);
        bus_read(O_WVAC, v); chk("R11 push after release", v, WFD - 1);
        bus_write(O_CTRL, 32'h4); bus_write(O_CTRL, 32'h0);

        // R12: soft reset of registers
        bus_write(O_SIZE, 32'h123);
        bus_write(O_CTRL, 32'h8);
        bus_read(O_GIE, v);  chk("R12 master enable", v, 0);
        bus_read(O_IER, v);  chk("R12 enables", v, 0);
        bus_read(O_ISR, v);  chk("R12 status bits", v, 0);
        bus_read(O_SIZE, v); chk("R12 size", v, 0);
        chk("R12 irq", 32'(irq), 0);
        bus_write(O_SIZE, 32'h55);
        bus_read(O_SIZE, v); chk("R12 write ignored while held", v, 0);
        bus_write(O_CTRL, 32'h0);
        bus_read(O_STAT, v); chk("R12 status after release", v, exp_status(1'b1, 4'h0));
        bus_write(O_SIZE, 7);
        bus_read(O_SIZE, v); chk("R12 writable again", v, 7);

        // R12: soft reset aborts a stalled readback
        bus_write(O_SIZE, 32'hFFF); bus_write(O_CTRL, 32'h2);
        poll_occ(RFD);
        bus_read(O_STAT, v); chk("R12 busy before abort", 32'(v[0]), 0);
        bus_write(O_CTRL, 32'h8);
        bus_read(O_STAT, v); chk("R12 done after abort", v, exp_status(1'b1, 4'h0));
        bus_read(O_ROCC, v); chk("R12 inbound flushed", v, 0);
        bus_write(O_CTRL, 32'h0);
        repeat (20) @(negedge clk);
        bus_read(O_ROCC, v); chk("R12 no capture after abort", v, 0);
        bus_read(O_WVAC, v); chk("R12 outbound empty", v, WFD);

        finish_run();
    end
endmodule